// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block is the multi-cycle arithmetic engine beside an 8-bit accumulator datapath. It has two operations. The multiply takes two 8-bit unsigned operands and returns their 16-bit product. The divide takes a 16-bit unsigned dividend and an 8-bit unsigned divisor and returns a 16-bit quotient and an 8-bit remainder. The surrounding CPU loads the operands and pulses a start input. It then waits on a one-cycle completion pulse and writes the registered results back to its register pair and byte register.

Each operation takes a fixed number of clock cycles, whatever the data: 32 for multiply and 50 for divide. Internally a shift-and-add loop does one multiplier bit per cycle, and a restoring shift-and-subtract loop does one quotient bit per cycle. Idle cycles then pad the run to the fixed count. A divisor of zero does not trap. It returns a saturated quotient, passes the low dividend byte through as the remainder, and raises a status flag.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_div_i`=0 (multiply), `quo_prod_o` is the unsigned product `mul_a_i` × `mul_b_i`, and `rem_o` is 0 while `div_zero_o` is 0.
- R2: With `op_div_i`=1 and a non-zero divisor, `quo_prod_o` is `dividend_i` / `divisor_i` and `rem_o` is `dividend_i` mod `divisor_i`, both unsigned, and `div_zero_o` is 0.
- R3: A multiply sampled at rising edge E0 shows `done_o`=1 in the cycle after edge E0+32, never earlier.
- R4: A divide sampled at rising edge E0 shows `done_o`=1 in the cycle after edge E0+50.
- R5: `busy_o` is 1 in every cycle from the one after the accepted start up to the cycle before `done_o`, and is 0 in the cycle where `done_o` is 1.
- R6: A start pulse while `busy_o`=1 is ignored: the result and the completion cycle of the running operation do not change, and no extra completion follows.
- R7: A divide with `divisor_i`=0 gives `quo_prod_o`=16'hFFFF, `rem_o`=`dividend_i[7:0]`, and `div_zero_o`=1 from the `done_o` cycle on.
- R8: `done_o` is high for exactly one cycle. `quo_prod_o`, `rem_o` and `div_zero_o` change only in the `done_o` cycle and hold until the next completion.
- R9: After reset `busy_o`, `done_o`, `div_zero_o`, `quo_prod_o` and `rem_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the rising edge |
| op_div_i | input | 1 | 0 selects multiply, 1 selects divide |
| mul_a_i | input | 8 | Multiply operand (accumulator) |
| mul_b_i | input | 8 | Multiply operand (second register) |
| dividend_i | input | 16 | Divide dividend (register pair) |
| divisor_i | input | 8 | Divide divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_prod_o | output | 16 | Product or quotient |
| rem_o | output | 8 | Remainder (0 after multiply) |
| div_zero_o | output | 1 | Last divide had a zero divisor |

## Verification
The multiply is run on all-ones by all-ones, on zero by a non-zero value, on one by a value, and on a series of operand pairs taken from an LFSR. The all-ones case exercises every carry into the top of the product. The zero and one cases show whether the multiplier bits are scanned in the right order. The divide is run on a maximal dividend over divisor 1 (full 16-bit quotient), over 255 (the largest partial remainder), on a dividend smaller than the divisor (zero quotient), on a zero dividend and on a zero divisor. Together these separate a wrong restore decision from a wrong quotient shift. A start pulse with different operands is also sent in mid-flight, to show that the running result and its timing do not change.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/md_seq_ctrl.sv
module md_seq_ctrl
  import muldiv_pkg::*;
#(
  parameter int MUL_LAT   = 32,
  parameter int DIV_LAT   = 50,
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 16,
  localparam int MaxLat   = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT,
  localparam int CW       = $clog2(MaxLat + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  input  md_op_e op_i,
  output logic   busy_o,
  output md_op_e op_o,
  output logic   step_o,
  output logic   finish_o
);
  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] lim, steps;
  logic          busy_q;
  md_op_e        op_q;

  assign lim   = (op_q == OP_DIV) ? CW'(DIV_LAT - 1) : CW'(MUL_LAT - 1);
  assign steps = (op_q == OP_DIV) ? CW'(DIV_STEPS)   : CW'(MUL_STEPS);

  assign step_o   = busy_q && (elapsed_q < steps);
  assign finish_o = busy_q && (elapsed_q == lim);
  assign busy_o   = busy_q;
  assign op_o     = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      op_q      <= OP_MUL;
      elapsed_q <= '0;
    end else if (accept_i) begin
      busy_q    <= 1'b1;
      op_q      <= op_i;
      elapsed_q <= '0;
    end else if (busy_q) begin
      busy_q    <= !finish_o;
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  // elapsed never runs past the selected limit
  p_elapsed_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> elapsed_q <= lim);
  p_finish_clears_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o && !accept_i |=> !busy_q);
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] p_q;
  logic [W-1:0]   mcand_q;
  logic [W:0]     sum;

  assign sum    = {1'b0, p_q[2*W-1:W]} + {1'b0, mcand_q};
  assign prod_o = p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q     <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      p_q     <= {{W{1'b0}}, b_i};
      mcand_q <= a_i;
    end else if (step_i) begin
      p_q <= p_q[0] ? {sum, p_q[W-1:1]} : {1'b0, p_q[2*W-1:1]};
    end
  end

  p_load_clears_upper_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> p_q[2*W-1:W] == '0);
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  logic [W-1:0]   r_q, d_q, diff;
  logic [2*W-1:0] q_q;
  logic [W:0]     trial;
  logic           fits;

  assign trial = {r_q, q_q[2*W-1]};
  assign fits  = trial >= {1'b0, d_q};
  assign diff  = trial[W-1:0] - d_q;  // fits W bits whenever fits=1
  assign quo_o = q_q;
  assign rem_o = r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
      q_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      r_q <= '0;
      q_q <= dividend_i;
      d_q <= divisor_i;
    end else if (step_i) begin
      r_q <= fits ? diff : trial[W-1:0];
      q_q <= {q_q[2*W-2:0], fits};
    end
  end

  p_partial_rem_lt_divisor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && d_q != '0 |=> r_q < d_q);
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W       = 8,
  parameter int MUL_LAT = 32,
  parameter int DIV_LAT = 50,
  localparam int MulSteps = W,
  localparam int DivSteps = 2 * W,
  localparam int MaxLat   = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT,
  localparam int CW       = $clog2(MaxLat + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           op_div_i,
  input  logic [W-1:0]   mul_a_i,
  input  logic [W-1:0]   mul_b_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] quo_prod_o,
  output logic [W-1:0]   rem_o,
  output logic           div_zero_o
);
  logic           accept, step, finish;
  md_op_e         op_run;
  logic [2*W-1:0] prod, quo;
  logic [W-1:0]   rem;
  logic           dz_q;
  logic [W-1:0]   dvd_lo_q;

  assign accept = start_i && !busy_o;

  md_seq_ctrl #(
    .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
    .MUL_STEPS(MulSteps), .DIV_STEPS(DivSteps)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .op_i     (op_div_i ? OP_DIV : OP_MUL),
    .busy_o   (busy_o),
    .op_o     (op_run),
    .step_o   (step),
    .finish_o (finish)
  );

  md_mul_core #(.W(W)) i_mul (
    .clk_i, .rst_ni,
    .load_i (accept && !op_div_i),
    .step_i (step && op_run == OP_MUL),
    .a_i    (mul_a_i),
    .b_i    (mul_b_i),
    .prod_o (prod)
  );

  md_div_core #(.W(W)) i_div (
    .clk_i, .rst_ni,
    .load_i     (accept && op_div_i),
    .step_i     (step && op_run == OP_DIV),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quo_o      (quo),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dz_q     <= 1'b0;
      dvd_lo_q <= '0;
    end else if (accept) begin
      dz_q     <= op_div_i && (divisor_i == '0);
      dvd_lo_q <= dividend_i[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      quo_prod_o <= '0;
      rem_o      <= '0;
      div_zero_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        div_zero_o <= dz_q;
        if (op_run == OP_MUL) begin
          quo_prod_o <= prod;
          rem_o      <= '0;
        end else if (dz_q) begin
          quo_prod_o <= '1;
          rem_o      <= dvd_lo_q;
        end else begin
          quo_prod_o <= quo;
          rem_o      <= rem;
        end
      end
    end
  end

  // latency checker: cycles counted while busy since the accepted start
  logic [CW-1:0] chk_cnt_q;
  md_op_e        chk_op_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt_q <= '0;
      chk_op_q  <= OP_MUL;
    end else if (accept) begin
      chk_cnt_q <= '0;
      chk_op_q  <= op_div_i ? OP_DIV : OP_MUL;
    end else if (busy_o) begin
      chk_cnt_q <= chk_cnt_q + 1'b1;
    end
  end

  p_mul_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && chk_op_q == OP_MUL |-> chk_cnt_q == CW'(MUL_LAT));
  p_div_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && chk_op_q == OP_DIV |-> chk_cnt_q == CW'(DIV_LAT));
  p_busy_after_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  p_idle_at_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_busy_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> $stable(chk_op_q));
  p_dz_saturates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> quo_prod_o == '1);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_results_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(quo_prod_o) && $stable(rem_o) && $stable(div_zero_o));
  p_mul_rem_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && chk_op_q == OP_MUL |-> rem_o == '0 && !div_zero_o);
endmodule

// File: tb/test_muldiv_seq.sv
module test_muldiv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MUL_LAT = 32;
  localparam int DIV_LAT = 50;

  typedef struct {
    logic [15:0] res;
    logic [7:0]  rem;
    logic        dz;
    int          t0;
    int          lat;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, op_div = 1'b0;
  logic [7:0]  a = '0, b = '0, dvs = '0;
  logic [15:0] dvd = '0;
  logic        busy, done, dz;
  logic [15:0] res;
  logic [7:0]  rem;

  int n_chk = 0, n_fail = 0, cyc = 0;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  muldiv_seq i_muldiv_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_div_i(op_div),
    .mul_a_i(a), .mul_b_i(b), .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .quo_prod_o(res), .rem_o(rem),
    .div_zero_o(dz)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pop expected item on each completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected done", 32'(res), 32'hdead);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res == e.res, e.dz ? "R7 quotient" : "R1/R2 result", 32'(res), 32'(e.res));
        check(rem == e.rem, e.dz ? "R7 remainder" : "R1/R2 remainder", 32'(rem), 32'(e.rem));
        check(dz == e.dz, "R7 div_zero flag", 32'(dz), 32'(e.dz));
        check(cyc - e.t0 == e.lat, e.lat == DIV_LAT ? "R4 latency" : "R3 latency",
              32'(cyc - e.t0), 32'(e.lat));
      end
    end
  end

  task automatic run_op(input bit div, input logic [7:0] ia, input logic [7:0] ib,
                        input logic [15:0] idvd, input logic [7:0] idvs,
                        input bit poke);
    exp_t e;
    logic [15:0] er; logic [7:0] em; logic ez;
    if (!div) begin
      er = 16'(ia) * 16'(ib); em = '0; ez = 1'b0;
    end else if (idvs == 0) begin
      er = 16'hFFFF; em = idvd[7:0]; ez = 1'b1;
    end else begin
      er = idvd / 16'(idvs); em = 8'(idvd % 16'(idvs)); ez = 1'b0;
    end
    @(negedge clk);
    start = 1'b1; op_div = div; a = ia; b = ib; dvd = idvd; dvs = idvs;
    @(negedge clk);
    e.res = er; e.rem = em; e.dz = ez; e.t0 = cyc; e.lat = div ? DIV_LAT : MUL_LAT;
    sb.push_back(e);
    start = 1'b0;
    check(busy == 1'b1, "R5 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; op_div = ~div; a = ~ia; b = 8'h5A; dvd = ~idvd; dvs = 8'h00;
      @(negedge clk);
      start = 1'b0; a = '0; b = '0; dvd = '0; dvs = '0;
    end
    while (!done) begin
      if (!busy) check(1'b0, "R5 busy dropped early", 32'(busy), 32'd1);
      @(negedge clk);
    end
    check(busy == 1'b0, "R5 busy low at done", 32'(busy), 32'd0);
    repeat (3) begin
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
      check(res == er && rem == em, "R8 results held", 32'({res, rem}), 32'({er, em}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !dz && res == 0 && rem == 0, "R9 reset state",
          32'({busy, done, dz, res, rem}), 32'd0);
    // R1 / R3 multiply patterns
    run_op(1'b0, 8'hFF, 8'hFF, '0, '0, 1'b0);
    run_op(1'b0, 8'h00, 8'hB7, '0, '0, 1'b0);
    run_op(1'b0, 8'h01, 8'h9C, '0, '0, 1'b0);
    run_op(1'b0, 8'h80, 8'h03, '0, '0, 1'b0);
    // R2 / R4 divide patterns
    run_op(1'b1, '0, '0, 16'hFFFF, 8'h01, 1'b0);
    run_op(1'b1, '0, '0, 16'hFFFF, 8'hFF, 1'b0);
    run_op(1'b1, '0, '0, 16'h1234, 8'h07, 1'b0);
    run_op(1'b1, '0, '0, 16'h0005, 8'hC8, 1'b0);
    run_op(1'b1, '0, '0, 16'h0000, 8'h13, 1'b0);
    // R7 zero divisor
    run_op(1'b1, '0, '0, 16'hBEEF, 8'h00, 1'b0);
    run_op(1'b1, '0, '0, 16'h0042, 8'h00, 1'b0);
    // R7 flag clears on a following good divide, then multiply
    run_op(1'b1, '0, '0, 16'h0100, 8'h10, 1'b0);
    // R6 start during busy ignored
    run_op(1'b0, 8'hD3, 8'h2F, '0, '0, 1'b1);
    run_op(1'b1, '0, '0, 16'hC0DE, 8'h0B, 1'b1);
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_op(lfsr[0], lfsr[15:8], lfsr[7:0], {lfsr[7:0], lfsr[15:8]},
             lfsr[11:4], 1'b0);
    end
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R6 no pending completions", 32'(sb.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule